// File: doc/BRIEF.md
# Multi-Cycle Pipeline Stage Scheduler

This block is the timing controller for a five-stage instruction pipeline (fetch, decode, execute, memory, write-back) whose stages keep an instruction for different numbers of cycles. Fetch and data access share one physical memory port, so the block only issues a fetch on every other cycle. Because of that cadence, fetch and data access never need the port in the same cycle. The block computes nothing itself. It tells the rest of the core which stage holds which instruction in each cycle, which client owns the memory port, and when the program counter advances.

A run begins with a one-cycle `start` pulse that carries an instruction count n. The first cycle after the pulse is cycle 1. Instruction k (counting from 0) is fetched in cycle 1+2k. It is in decode during cycles 2+2k and 3+2k, in execute during cycles 4+2k and 5+2k, in memory during cycle 6+2k and in write-back during cycle 7+2k. A run of n instructions therefore takes 2n+5 cycles. After the last write-back the block goes idle and waits for the next `start`. The fetch address counter starts at word 0, which is the bottom of the instruction half of a 2048-word memory.

Top module: `pipe_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, and afterwards until a run is launched, every bit of `stage_valid` is 0, `done` is 0, `pc_inc` is 0, `mem_sel` is 2'b00 and `fetch_pc` is 0.
- R2: During a run of n instructions, instruction k (k < n) is in fetch in cycle 1+2k. In that cycle `stage_valid[0]` is 1, `idx_if` is k, `pc_inc` is 1 and `fetch_pc` is k. `fetch_pc` increments by one after each fetch.
- R3: Instruction k is in decode (`stage_valid[1]`, `idx_id`) in cycles 2+2k and 3+2k, in execute (`stage_valid[2]`, `idx_ex`) in cycles 4+2k and 5+2k, in memory (`stage_valid[3]`, `idx_mem`) in cycle 6+2k and in write-back (`stage_valid[4]`, `idx_wb`) in cycle 7+2k. Each stage's index output gives k whenever that stage's valid bit is 1.
- R4: `mem_sel` is 2'b01 (fetch) in any cycle with a valid fetch, 2'b10 (data) in any cycle with a valid memory stage, and 2'b00 (idle) otherwise. Fetch and memory stages are never valid in the same cycle.
- R5: No more than four bits of `stage_valid` are set in any cycle.
- R6: `done` is 1 for exactly one cycle, cycle 2n+5, which is the last instruction's write-back. In the cycle after it all `stage_valid` bits are 0.
- R7: No stage is ever valid for an index of n or above. After the last fetch, `pc_inc` stays low and `fetch_pc` holds the value n.
- R8: A `start` sampled while a run is in progress, including the cycle in which `done` is 1, is ignored. The current run's timing and indices stay the same, and no new run begins.
- R9: With n = 0, `done` is 1 in cycle 1 and no stage is ever valid.
- R10: A `start` sampled while idle launches a new run, which clears `fetch_pc` to 0. This works on the first cycle after `done`.
- R11: A synchronous reset during a run clears all stage valid bits, `fetch_pc` and the run state by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, taken only when idle |
| instr_count | input | CNT_W | Number of instructions n, captured with start |
| stage_valid | output | 5 | Stage occupied: bit0 fetch, bit1 decode, bit2 execute, bit3 memory, bit4 write-back |
| idx_if | output | CNT_W | Index of instruction in fetch |
| idx_id | output | CNT_W | Index of instruction in decode |
| idx_ex | output | CNT_W | Index of instruction in execute |
| idx_mem | output | CNT_W | Index of instruction in memory |
| idx_wb | output | CNT_W | Index of instruction in write-back |
| mem_sel | output | 2 | Shared port owner: 00 idle, 01 fetch, 10 data |
| pc_inc | output | 1 | Program counter advance strobe |
| fetch_pc | output | PC_W | Current fetch word address |
| done | output | 1 | One-cycle pulse in the last write-back cycle |

## Verification
Two situations are hard to reach from the ports. The first is a `start` that arrives exactly in the `done` cycle: the block still counts as busy then and must drop the request, and one cycle later it must accept a request. The bench raises `start` in that exact cycle and checks that the block stays idle. It then launches back-to-back. The second is the upper end of the cycle counter, which only a run at the maximum count of 255 reaches (515 cycles). The vector table includes that run, and it also includes a `start` raised in the middle of a run with a different count.

// File: rtl/pipe_sched_pkg.sv
// Shared definitions for the pipeline stage scheduler.
// Assumes a fixed five-stage order: fetch, decode, execute, memory, write-back.
package pipe_sched_pkg;

    localparam int NUM_STAGES = 5;
    localparam int ST_IF  = 0;
    localparam int ST_ID  = 1;
    localparam int ST_EX  = 2;
    localparam int ST_MEM = 3;
    localparam int ST_WB  = 4;

    // Owner of the single shared memory port.
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'b00,
        PORT_FETCH = 2'b01,
        PORT_DATA  = 2'b10
    } port_sel_e;

    // Cycle in which instruction 0 enters a stage (cycle 1 follows start).
    function automatic int entry_cycle(input int stage);
        case (stage)
            ST_IF:   return 1;
            ST_ID:   return 2;
            ST_EX:   return 4;
            ST_MEM:  return 6;
            default: return 7;
        endcase
    endfunction

    // Number of cycles an instruction stays in a stage.
    function automatic int hold_cycles(input int stage);
        case (stage)
            ST_ID, ST_EX: return 2;
            default:      return 1;
        endcase
    endfunction

endpackage

// File: rtl/pipe_sched_ctrl.sv
// Run controller: captures the instruction count on an accepted start,
// counts cycles of the run, counts issued fetches and flags the final cycle.
// Assumes a start is only taken while idle; the run ends in cycle 2n+5
// (or cycle 1 when n is zero).
module pipe_sched_ctrl #(
    parameter int CNT_W = 8,
    parameter int CYC_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] instr_count,
    input  logic             fetch_fire,
    output logic             busy,
    output logic             launch,
    output logic [CYC_W-1:0] cyc,
    output logic [CNT_W-1:0] n_lat,
    output logic [CNT_W-1:0] issued,
    output logic             last
);

    localparam int TAIL = 5;

    logic [CYC_W-1:0] last_cyc;

    // Final cycle of the run: write-back of the last instruction.
    always_comb begin
        if (n_lat == '0)
            last_cyc = CYC_W'(1);
        else
            last_cyc = CYC_W'({n_lat, 1'b0}) + CYC_W'(TAIL);
    end

    // Start is honoured only when no run is in progress.
    always_comb launch = start && !busy;

    // Final-cycle flag of the current run.
    always_comb last = busy && (cyc == last_cyc);

    // Run state: busy flag, cycle counter, latched count, issued fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cyc    <= '0;
            n_lat  <= '0;
            issued <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            cyc    <= CYC_W'(1);
            n_lat  <= instr_count;
            issued <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                cyc  <= '0;
            end else begin
                cyc <= cyc + CYC_W'(1);
            end
            if (fetch_fire)
                issued <= issued + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pipe_sched_stage.sv
// One pipeline stage's occupancy decoder. From the run cycle it derives
// which instruction (if any) sits in the stage, given the cycle in which
// instruction 0 enters and how long each instruction stays.
// Assumes instructions enter every two cycles and HOLD is 1 or 2.
module pipe_sched_stage #(
    parameter int CNT_W = 8,
    parameter int CYC_W = CNT_W + 2,
    parameter int ENTRY = 1,
    parameter int HOLD  = 1
) (
    input  logic             busy,
    input  logic [CYC_W-1:0] cyc,
    input  logic [CNT_W-1:0] n_lat,
    input  logic             allow,
    output logic             valid,
    output logic [CNT_W-1:0] idx
);

    logic [CYC_W-1:0] rel;
    logic [CYC_W-2:0] slot;
    logic             started;
    logic             in_phase;

    // Position of the run relative to this stage's first occupancy.
    always_comb begin
        rel      = cyc - CYC_W'(ENTRY);
        slot     = rel[CYC_W-1:1];
        started  = (cyc >= CYC_W'(ENTRY));
        in_phase = (HOLD >= 2) || !rel[0];
    end

    // Occupancy and instruction index of this stage.
    always_comb begin
        valid = busy && started && in_phase && allow
                && (slot < {1'b0, n_lat});
        idx   = slot[CNT_W-1:0];
    end

endmodule

// File: rtl/pipe_sched_port.sv
// Shared memory port arbiter and fetch address counter. Grants the port to
// fetch or to data access and advances the fetch address after each fetch.
// Assumes the stage decoders never request both clients in one cycle.
module pipe_sched_port #(
    parameter int PC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic            fetch_v,
    input  logic            data_v,
    output logic [1:0]      mem_sel,
    output logic            pc_inc,
    output logic [PC_W-1:0] pc
);

    import pipe_sched_pkg::*;

    port_sel_e sel;

    // Port owner for this cycle.
    always_comb begin
        if (fetch_v)
            sel = PORT_FETCH;
        else if (data_v)
            sel = PORT_DATA;
        else
            sel = PORT_IDLE;
        mem_sel = sel;
        pc_inc  = fetch_v;
    end

    // Fetch address: cleared at launch, advanced after each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (launch)
            pc <= '0;
        else if (fetch_v)
            pc <= pc + PC_W'(1);
    end

endmodule

// File: rtl/pipe_sched.sv
// Top of the multi-cycle pipeline stage scheduler. Sequences n instructions
// through five stages with unequal residence times, with fetch every other
// cycle so fetch and data access never share the memory port.
// Assumes a synchronous active-low reset and a one-cycle start pulse.
module pipe_sched #(
    parameter int CNT_W = 8,
    parameter int PC_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] instr_count,
    output logic [4:0]       stage_valid,
    output logic [CNT_W-1:0] idx_if,
    output logic [CNT_W-1:0] idx_id,
    output logic [CNT_W-1:0] idx_ex,
    output logic [CNT_W-1:0] idx_mem,
    output logic [CNT_W-1:0] idx_wb,
    output logic [1:0]       mem_sel,
    output logic             pc_inc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             done
);

    import pipe_sched_pkg::*;

    localparam int CYC_W = CNT_W + 2;

    logic             busy;
    logic             launch;
    logic             last;
    logic [CYC_W-1:0] cyc;
    logic [CNT_W-1:0] n_lat;
    logic [CNT_W-1:0] issued;
    logic [NUM_STAGES-1:0] allow_v;
    logic [NUM_STAGES-1:0] valid_v;
    logic [CNT_W-1:0] stage_idx [NUM_STAGES];

    pipe_sched_ctrl #(
        .CNT_W(CNT_W),
        .CYC_W(CYC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .instr_count(instr_count),
        .fetch_fire (valid_v[ST_IF]),
        .busy       (busy),
        .launch     (launch),
        .cyc        (cyc),
        .n_lat      (n_lat),
        .issued     (issued),
        .last       (last)
    );

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        if (s == ST_IF) begin : g_gate
            // Fetch is additionally gated by the issued-instruction count.
            assign allow_v[s] = (issued < n_lat);
        end else begin : g_open
            assign allow_v[s] = 1'b1;
        end

        pipe_sched_stage #(
            .CNT_W(CNT_W),
            .CYC_W(CYC_W),
            .ENTRY(entry_cycle(s)),
            .HOLD (hold_cycles(s))
        ) u_stage (
            .busy (busy),
            .cyc  (cyc),
            .n_lat(n_lat),
            .allow(allow_v[s]),
            .valid(valid_v[s]),
            .idx  (stage_idx[s])
        );
    end

    pipe_sched_port #(
        .PC_W(PC_W)
    ) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .fetch_v(valid_v[ST_IF]),
        .data_v (valid_v[ST_MEM]),
        .mem_sel(mem_sel),
        .pc_inc (pc_inc),
        .pc     (fetch_pc)
    );

    // Drive stage outputs from the per-stage decoders.
    always_comb begin
        stage_valid = valid_v;
        idx_if      = stage_idx[ST_IF];
        idx_id      = stage_idx[ST_ID];
        idx_ex      = stage_idx[ST_EX];
        idx_mem     = stage_idx[ST_MEM];
        idx_wb      = stage_idx[ST_WB];
        done        = last;
    end

endmodule

// File: rtl/pipe_sched_chk.sv
// Protocol checker for the stage scheduler, attached to every instance by
// bind. Assumes the port encodings stated in the requirements.
module pipe_sched_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       stage_valid,
    input logic [CNT_W-1:0] idx_ex,
    input logic [CNT_W-1:0] idx_mem,
    input logic [CNT_W-1:0] idx_wb,
    input logic [1:0]       mem_sel,
    input logic             pc_inc,
    input logic             done
);

    // R4: fetch and data access never claim the port together.
    assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stage_valid[0] && stage_valid[3]));

    // R4: a valid fetch owns the port with the fetch code.
    assert_fetch_owns_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid[0] |-> (mem_sel == 2'b01));

    // R5: at most four stages occupied.
    assert_inflight_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stage_valid) <= 4);

    // R6: after done every stage is empty.
    assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (stage_valid == 5'b0));

    // R2: the advance strobe only comes with a valid fetch.
    assert_strobe_with_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> (mem_sel == 2'b01));

    // R3: memory stage holds the instruction that left execute.
    assert_mem_after_ex_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid[3] |-> ($past(stage_valid[2]) && (idx_mem == $past(idx_ex))));

    // R3: write-back holds the instruction that left memory.
    assert_wb_after_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid[4] |-> ($past(stage_valid[3]) && (idx_wb == $past(idx_mem))));

endmodule

bind pipe_sched pipe_sched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_valid(stage_valid),
    .idx_ex     (idx_ex),
    .idx_mem    (idx_mem),
    .idx_wb     (idx_wb),
    .mem_sel    (mem_sel),
    .pc_inc     (pc_inc),
    .done       (done)
);

// File: tb/pipe_sched_test.sv
module pipe_sched_test;

    localparam int CNT_W = 8;
    localparam int PC_W  = 11;
    localparam int NVEC  = 7;
    // Each entry: {instruction count, expected run length in cycles}.
    localparam int VEC [NVEC][2] = '{
        '{1, 7}, '{2, 9}, '{3, 11}, '{7, 19}, '{5, 15}, '{12, 29}, '{255, 515}
    };
    localparam int ENTRY [5] = '{1, 2, 4, 6, 7};
    localparam int HOLD  [5] = '{1, 2, 2, 1, 1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] instr_count = '0;
    logic [4:0]       stage_valid;
    logic [CNT_W-1:0] idx_if, idx_id, idx_ex, idx_mem, idx_wb;
    logic [1:0]       mem_sel;
    logic             pc_inc;
    logic [PC_W-1:0]  fetch_pc;
    logic             done;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;

    always #4 clk = ~clk;

    pipe_sched #(.CNT_W(CNT_W), .PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_count(instr_count),
        .stage_valid(stage_valid), .idx_if(idx_if), .idx_id(idx_id),
        .idx_ex(idx_ex), .idx_mem(idx_mem), .idx_wb(idx_wb),
        .mem_sel(mem_sel), .pc_inc(pc_inc), .fetch_pc(fetch_pc), .done(done)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d at tick %0d", req, got, exp, ticks);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=%0d expected=%0d", ticks, 150000);
            finish_run();
        end
    end

    function automatic int stage_idx(input int s);
        case (s)
            0: return int'(idx_if);
            1: return int'(idx_id);
            2: return int'(idx_ex);
            3: return int'(idx_mem);
            default: return int'(idx_wb);
        endcase
    endfunction

    // Compare all outputs with the timing rules for cycle c of a run of n.
    task automatic check_cycle(input int c, input int n, input int total);
        logic [4:0] ev;
        int ek [5];
        int fetched;
        int esel;
        for (int s = 0; s < 5; s++) begin
            int rel;
            rel = c - ENTRY[s];
            ek[s] = (rel >= 0) ? rel / 2 : 0;
            ev[s] = (rel >= 0) && (ek[s] < n) && (HOLD[s] == 2 || (rel % 2) == 0);
        end
        check(stage_valid == ev, "R3/R7 stage_valid", stage_valid, ev);
        for (int s = 0; s < 5; s++)
            if (ev[s]) check(stage_idx(s) == ek[s], "R3 stage index", stage_idx(s), ek[s]);
        esel = ev[0] ? 1 : (ev[3] ? 2 : 0);
        check(mem_sel == 2'(esel), "R4 mem_sel", mem_sel, esel);
        fetched = (c / 2 < n) ? c / 2 : n;
        check(fetch_pc == PC_W'(fetched), "R2 fetch_pc", fetch_pc, fetched);
        check(pc_inc == ev[0], "R2 pc_inc", pc_inc, ev[0]);
        check(done == (c == total), "R6 done", done, c == total);
        check($countones(stage_valid) <= 4, "R5 in-flight", $countones(stage_valid), 4);
    endtask

    // Launch a run. poke: 0 none, 1 start with another count mid-run (R8),
    // 2 start raised during the done cycle (R8).
    task automatic run_case(input int n, input int total, input int poke);
        @(negedge clk);
        start = 1'b1;
        instr_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        instr_count = '0;
        for (int c = 1; c <= total; c++) begin
            check_cycle(c, n, total);
            if (poke == 1 && c == 3) begin
                start = 1'b1;
                instr_count = CNT_W'(n + 3);
            end else if (poke == 2 && c == total) begin
                start = 1'b1;
                instr_count = CNT_W'(4);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(stage_valid == 5'b0, "R6/R8 idle after run", stage_valid, 0);
        check(done == 1'b0, "R6 single done pulse", done, 0);
        check(fetch_pc == PC_W'(n), "R7 fetch_pc holds n", fetch_pc, n);
        check(pc_inc == 1'b0, "R7 no strobe after run", pc_inc, 0);
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(stage_valid == 5'b0 && done == 1'b0 && pc_inc == 1'b0,
              "R1 reset outputs", {stage_valid, done, pc_inc}, 0);
        check(mem_sel == 2'b00 && fetch_pc == '0, "R1 reset port", {mem_sel, fetch_pc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stage_valid == 5'b0 && mem_sel == 2'b00, "R1 idle after reset",
              stage_valid, 0);

        // Table walk: R2 R3 R4 R5 R6 R7, back-to-back launches (R10).
        for (int i = 0; i < NVEC; i++)
            run_case(VEC[i][0], VEC[i][1], 0);

        // R8: start with another count mid-run is ignored.
        run_case(4, 13, 1);
        // R8: start in the done cycle is ignored (run_case checks idle after).
        run_case(3, 11, 2);
        @(negedge clk);
        check(stage_valid == 5'b0 && fetch_pc == PC_W'(3), "R8 no run from done-cycle start",
              {stage_valid, fetch_pc}, 3);

        // R10: relaunch clears fetch_pc and replays timing.
        run_case(2, 9, 0);

        // R9: zero instructions.
        @(negedge clk);
        start = 1'b1;
        instr_count = '0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R9 done in cycle 1", done, 1);
        check(stage_valid == 5'b0, "R9 no stage valid", stage_valid, 0);
        check(fetch_pc == '0 && pc_inc == 1'b0, "R9 no fetch", {fetch_pc, pc_inc}, 0);
        @(negedge clk);
        check(done == 1'b0 && stage_valid == 5'b0, "R9 idle after", {done, stage_valid}, 0);

        // R11: reset in the middle of a run.
        @(negedge clk);
        start = 1'b1;
        instr_count = CNT_W'(6);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check(stage_valid != 5'b0, "R11 run active before reset", stage_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(stage_valid == 5'b0 && fetch_pc == '0, "R11 cleared by reset",
              {stage_valid, fetch_pc}, 0);
        check(done == 1'b0 && mem_sel == 2'b00, "R11 port idle", {done, mem_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stage_valid == 5'b0, "R11 stays idle", stage_valid, 0);
        run_case(2, 9, 0);

        finish_run();
    end

endmodule